// File: doc/BRIEF.md
# Per-Input Interrupt Trigger Qualifier

This block conditions sixteen raw interrupt lines before they reach the request registers of a pair of cascaded interrupt controllers. Each line can be set to respond to a rising edge or to an active-low level. The choice is made by one bit per line in two 8-bit control registers, and software reads and writes those registers a byte at a time. The result is a qualified request vector, with one bit per line, that the controllers' priority logic consumes. The priority logic itself lies outside this block.

Every line first passes through a two-stage synchronizer. In edge mode, a rising transition is caught in a hold register. That register keeps the request until the controller accepts the line into service or is reinitialized. In level mode, the request simply follows the synchronized line while it is low, so a line that is still low after service requests again. Five lines (0, 1, 2, 8 and 13) are wired to edge mode and their control bits cannot be written. The trigger-mode bit in the initialization command word is ignored: an initialization write only clears the captured edges.

Top module: `trig_qualifier`

## Requirements
- R1: After reset both control registers read 0x00, every line is in edge mode and `req_out` is all zero.
- R2: Control bits for lines 0, 1, 2, 8 and 13 ignore writes and always read 0. Those lines stay in edge mode, so driving them low raises no request.
- R3: A write with `reg_sel`=0 stores the byte as the modes of lines 7..0, and `reg_sel`=1 stores lines 15..8, with bit n of the byte belonging to the lowest line of that byte plus n. The stored value reads back on `reg_rdata` in the cycle after the write (fixed bits as 0). A control bit of 1 selects level mode and 0 selects edge mode.
- R4: In edge mode, a 0-to-1 change on `irq_in[n]` sets `req_out[n]` three clock edges after the change. A line held high after its request was acknowledged raises no further request.
- R5: In level mode, `req_out[n]` is 1 while `irq_in[n]` is low and 0 while it is high, following the input two clock edges later.
- R6: In level mode, an acknowledge of the line does not remove the request while the line stays low.
- R7: An `ack_valid` pulse with `ack_id`=n clears a captured edge request on line n at the next clock edge and leaves all other lines unchanged. A new edge in the same cycle wins.
- R8: `init_wr` clears every captured edge request at the next edge, whatever the value of `init_cmd`. Bit 3 of `init_cmd` (the global trigger-mode bit) does not change any line's mode.
- R9: In edge mode, a captured request stays set after the input returns low, until it is acknowledged or cleared by an initialization. A 1-to-0 change raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Raw interrupt lines, bit n is line n |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Register select: 0 lines 7..0, 1 lines 15..8 |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Selected control register, fixed bits as 0 |
| ack_valid | input | 1 | A line was accepted into service |
| ack_id | input | 4 | Number of the line accepted |
| init_wr | input | 1 | Initialization command written to the controller |
| init_cmd | input | 8 | Initialization command byte; has no effect on modes |
| req_out | output | 16 | Qualified request vector |

## Verification
The properties assume that reset has been released for at least three cycles before the first register write, because the internal reset release lags the port by two edges. They also assume that a register readback is judged on the same `reg_sel` that was written. The bench holds all control strobes low for several cycles after reset and changes `reg_sel` only together with a write or a read. It moves `irq_in` only on falling clock edges and waits the full synchronizer-plus-hold latency before it samples `req_out`.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int unsigned DEF_LANE_W      = 8;
  localparam int unsigned DEF_N_CTRL      = 2;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam logic [15:0] DEF_FIXED_EDGE  = 16'h2107;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/trig_ctrl_regs.sv
module trig_ctrl_regs #(
  parameter int unsigned               N_CTRL     = 2,
  parameter int unsigned               LANE_W     = 8,
  parameter int unsigned               SEL_W      = 1,
  parameter logic [N_CTRL*LANE_W-1:0]  FIXED_EDGE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [LANE_W-1:0]        wdata_i,
  output logic [LANE_W-1:0]        rdata_o,
  output logic [N_CTRL*LANE_W-1:0] mode_o
);

  genvar l;
  generate
    for (l = 0; l < N_CTRL; l++) begin : g_lane
      localparam logic [LANE_W-1:0] LANE_FIX = FIXED_EDGE[l*LANE_W +: LANE_W];
      logic              lane_en;
      logic [LANE_W-1:0] lane_d;
      logic [LANE_W-1:0] lane_q;

      always_comb begin
        lane_en = wr_i && (sel_i == SEL_W'(l));
        lane_d  = wdata_i & ~LANE_FIX;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= '0;
        end else if (lane_en) begin
          lane_q <= lane_d;
        end
      end

      assign mode_o[l*LANE_W +: LANE_W] = lane_q;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (sel_i == SEL_W'(k)) begin
        rdata_o = mode_o[k*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic             flush_i,
  output logic [WIDTH-1:0] req_o
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      logic is_level;
      logic rise;
      logic prev_q;
      logic prev_d;
      logic hold_q;
      logic hold_d;

      always_comb begin
        is_level = (trig_mode_e'(mode_i[i]) == TRIG_LEVEL);
        rise     = sync_i[i] & ~prev_q;
        prev_d   = sync_i[i];
        hold_d   = hold_q;
        if (is_level) begin
          hold_d = 1'b0;
        end else if (flush_i) begin
          hold_d = 1'b0;
        end else if (rise) begin
          hold_d = 1'b1;
        end else if (clr_i[i]) begin
          hold_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          hold_q <= 1'b0;
        end else begin
          prev_q <= prev_d;
          hold_q <= hold_d;
        end
      end

      assign req_o[i] = is_level ? ~sync_i[i] : hold_q;
    end
  endgenerate

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_pkg::*;
#(
  parameter int unsigned N_CTRL      = DEF_N_CTRL,
  parameter int unsigned LANE_W      = DEF_LANE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter logic [N_CTRL*LANE_W-1:0] FIXED_EDGE = DEF_FIXED_EDGE,
  localparam int unsigned NUM_IRQ    = N_CTRL * LANE_W,
  localparam int unsigned ID_W       = $clog2(NUM_IRQ),
  localparam int unsigned SEL_W      = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [LANE_W-1:0]  reg_wdata,
  output logic [LANE_W-1:0]  reg_rdata,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               init_wr,
  input  logic [7:0]         init_cmd,
  output logic [NUM_IRQ-1:0] req_out
);

  logic               rst_n_int;
  logic [NUM_IRQ-1:0] irq_sync;
  logic [NUM_IRQ-1:0] line_mode;
  logic [NUM_IRQ-1:0] ack_vec;
  logic               unused_init_cmd;

  // The command byte, including its trigger-mode bit, never steers a mode.
  assign unused_init_cmd = ^init_cmd;

  always_comb begin
    ack_vec = '0;
    if (ack_valid) begin
      ack_vec[ack_id] = 1'b1;
    end
  end

  trig_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  trig_sync #(
    .WIDTH  (NUM_IRQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (irq_in),
    .q_o   (irq_sync)
  );

  trig_ctrl_regs #(
    .N_CTRL     (N_CTRL),
    .LANE_W     (LANE_W),
    .SEL_W      (SEL_W),
    .FIXED_EDGE (FIXED_EDGE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_i    (reg_wr),
    .sel_i   (reg_sel),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .mode_o  (line_mode)
  );

  trig_detect #(
    .WIDTH (NUM_IRQ)
  ) u_detect (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sync_i  (irq_sync),
    .mode_i  (line_mode),
    .clr_i   (ack_vec),
    .flush_i (init_wr),
    .req_o   (req_out)
  );

endmodule

// File: rtl/trig_qualifier_chk.sv
module trig_qualifier_chk
  import trig_pkg::*;
#(
  parameter int unsigned N_CTRL = DEF_N_CTRL,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter logic [N_CTRL*LANE_W-1:0] FIXED_EDGE = DEF_FIXED_EDGE,
  localparam int unsigned NUM_IRQ = N_CTRL * LANE_W,
  localparam int unsigned ID_W    = $clog2(NUM_IRQ),
  localparam int unsigned SEL_W   = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [SEL_W-1:0]   reg_sel,
  input logic [LANE_W-1:0]  reg_wdata,
  input logic [LANE_W-1:0]  reg_rdata,
  input logic               ack_valid,
  input logic [ID_W-1:0]    ack_id,
  input logic               init_wr,
  input logic [NUM_IRQ-1:0] req_out
);

  logic [LANE_W-1:0]  sel_fix;
  logic [NUM_IRQ-1:0] clr_seen;

  always_comb begin
    sel_fix = '0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (reg_sel == SEL_W'(k)) begin
        sel_fix = FIXED_EDGE[k*LANE_W +: LANE_W];
      end
    end
    clr_seen = '0;
    if (init_wr) begin
      clr_seen = '1;
    end else if (ack_valid) begin
      clr_seen[ack_id] = 1'b1;
    end
  end

  // R2
  fixed_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & sel_fix) == '0);

  // R3
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_sel != $past(reg_sel)) ||
               (reg_rdata == ($past(reg_wdata) & ~$past(sel_fix))));

  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (req_out & FIXED_EDGE) == '0);

  // R9
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(req_out) & ~req_out) & FIXED_EDGE) & ~$past(clr_seen)) == '0);

endmodule

bind trig_qualifier trig_qualifier_chk u_chk (.*);

// File: tb/trig_qualifier_tb.sv
module trig_qualifier_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        reg_wr;
  logic [0:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        ack_valid;
  logic [3:0]  ack_id;
  logic        init_wr;
  logic [7:0]  init_cmd;
  logic [15:0] req_out;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] FIXED    = 16'h2107;
  localparam logic [15:0] TBL_MODE = 16'h0EF0;
  localparam int          N_PAT    = 6;
  localparam logic [15:0] PAT [N_PAT] = '{16'h0001, 16'hFFFF, 16'hA5A5,
                                          16'h5A5A, 16'h8001, 16'h0000};

  always #10 clk = ~clk;

  trig_qualifier u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .init_wr   (init_wr),
    .init_cmd  (init_cmd),
    .req_out   (req_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] data);
    reg_sel   = sel;
    reg_wdata = data;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic ack_line(input logic [3:0] id);
    ack_id    = id;
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic reinit(input logic [7:0] cmd);
    init_cmd = cmd;
    init_wr  = 1'b1;
    @(negedge clk);
    init_wr  = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n     = 1'b0;
    irq_in    = '0;
    reg_wr    = 1'b0;
    reg_sel   = '0;
    reg_wdata = '0;
    ack_valid = 1'b0;
    ack_id    = '0;
    init_wr   = 1'b0;
    init_cmd  = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(5);

    // R1 reset state
    check("R1 req", req_out, 16'h0000);
    read_reg(1'b0, rd);
    check("R1 lo", {8'h00, rd}, 16'h0000);
    read_reg(1'b1, rd);
    check("R1 hi", {8'h00, rd}, 16'h0000);

    // R3 mode setup for the vector walk
    write_reg(1'b0, 8'hF0);
    write_reg(1'b1, 8'h0F);
    read_reg(1'b1, rd);
    check("R3 hi readback", {8'h00, rd}, 16'h000E);

    // R4 R5 vector walk: edge lines follow rises, level lines follow lows
    for (int p = 0; p < N_PAT; p++) begin
      irq_in = 16'h0000;
      cycles(3);
      reinit(8'h10);
      irq_in = PAT[p];
      cycles(3);
      check($sformatf("R4/R5 pattern %0d", p), req_out, PAT[p] ^ TBL_MODE);
    end

    // R2 R3 writes to fixed bits ignored
    write_reg(1'b0, 8'hFF);
    write_reg(1'b1, 8'hFF);
    read_reg(1'b0, rd);
    check("R2 R3 lo readback", {8'h00, rd}, 16'h00F8);
    read_reg(1'b1, rd);
    check("R2 R3 hi readback", {8'h00, rd}, 16'h00DE);

    // R5 level lines request while low; R2 fixed lines do not
    irq_in = 16'hFFFF;
    cycles(4);
    reinit(8'h10);
    irq_in = 16'h0000;
    cycles(3);
    check("R5 R2 low levels", req_out, 16'hDEF8);

    // R6 acknowledge does not drop a held level
    ack_line(4'd3);
    check("R6 level after ack", req_out, 16'hDEF8);

    // R4 R5 rise on all: fixed lines latch, level lines release
    irq_in = 16'hFFFF;
    cycles(3);
    check("R4 R5 all high", req_out, FIXED);

    // R7 acknowledge clears one line only
    ack_line(4'd0);
    check("R7 ack line 0", req_out, 16'h2106);

    // R4 held high raises nothing more
    cycles(5);
    check("R4 no re-raise", req_out, 16'h2106);

    // R8 init clears edges, trigger-mode bit ignored
    reinit(8'h18);
    check("R8 cleared", req_out, 16'h0000);
    read_reg(1'b0, rd);
    check("R8 mode kept", {8'h00, rd}, 16'h00F8);
    irq_in = 16'h0000;
    cycles(3);
    check("R8 level still active", req_out, 16'hDEF8);

    // R9 pulse held until acknowledged
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h00);
    cycles(3);
    reinit(8'h10);
    irq_in = 16'h0020;
    cycles(1);
    irq_in = 16'h0000;
    cycles(3);
    check("R9 pulse held", req_out, 16'h0020);
    ack_line(4'd5);
    check("R7 ack line 5", req_out, 16'h0000);

    // R9 falling change raises nothing
    irq_in = 16'h0040;
    cycles(3);
    check("R4 rise line 6", req_out, 16'h0040);
    ack_line(4'd6);
    irq_in = 16'h0000;
    cycles(4);
    check("R9 fall no request", req_out, 16'h0000);

    summary();
    $finish;
  end

endmodule